// File: doc/BRIEF.md
# Master-Synchronized Multi-Phase PWM Generator

This block produces several PWM signals that all hang off one shared master time base. A single master counter runs from zero up to the programmed period minus one and then wraps. Each timing unit derives its own phase counter from the master count, shifted back by that unit's phase offset. The unit drives its PWM line high while its phase counter sits below its duty value. Because every unit follows the one master count, the phase relation between interleaved channels is fixed by the hardware and cannot drift. For N evenly interleaved phases, software writes offsets of k times period/N.

Software changes the period, the duties and the offsets through a shadow stage. A single update strobe captures the whole set, and the captured set becomes active on every unit in the same cycle, at the first master period start after the strobe. A PWM cycle therefore never mixes an old and a new setting. Dropping the enable parks the master and all phase counters at zero and forces every output low. Raising the enable again restarts the pattern from the top of a period.

Top module: `mphase_pwm`

## Requirements
- R1: While the reset input is low and until the first update after reset, every PWM output and the period-start output are low.
- R2: One cycle after enable is sampled low, all PWM outputs and the period-start output are low. When enable returns high, the first running cycle has master count 0.
- R3: While running, the master count steps 0, 1, …, P−1 and then returns to 0, where P is the active period. The period-start output is high exactly in the cycles where the master count is 0. It therefore pulses once every P cycles, including the first running cycle, and it stays high in every running cycle when P is 0 or 1.
- R4: While running, output k is high exactly when ((m − off_k) mod P) < duty_k. Here m is the master count, off_k is unit k's effective offset and duty_k is unit k's duty.
- R5: A duty of 0 keeps its output low. A non-zero duty of P or more keeps its output high in every running cycle.
- R6: An offset of P or more is treated as an offset of 0.
- R7: A high update strobe in a clock cycle captures period, all duties and all offsets together. The new values become active on all units at once, starting with the first period-start cycle at least two cycles after the strobe cycle. A strobe in the last cycle of a period therefore waits one full period. A strobe while idle takes effect from the first running cycle after enable.
- R8: Changing the period, duty or offset inputs without an update strobe has no effect on any output.
- R9: Unit k takes its duty and offset from bits [k·CNT_W +: CNT_W] of the flat duty and offset buses and drives PWM bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Run enable for the master and all units |
| update_i | input | 1 | Strobe that captures period, duties and offsets into the shadow stage |
| period_i | input | CNT_W | Shared period in counter ticks |
| duty_i | input | NUM_UNITS·CNT_W | Per-unit duty values, unit k at bits [k·CNT_W +: CNT_W] |
| offset_i | input | NUM_UNITS·CNT_W | Per-unit phase offsets, same packing as duty_i |
| pwm_o | output | NUM_UNITS | One PWM line per unit |
| period_start_o | output | 1 | High in each cycle where the master count is 0 |

## Verification
The first pattern is a four-phase quarter-period interleave with equal duties. It shows whether each unit is shifted by its own offset and by nothing else, and a wrong sign or a wrong modulo in the phase arithmetic breaks it. The second pattern uses duties of zero, exactly the period and above the period, together with an offset beyond the period. It separates the constant-level cases and the out-of-range offset from the normal compare. Strobes are placed mid-period, on the last cycle of a period and while idle, so the bench can tell apart an immediate load, a load at the next rollover and a load deferred by one full period. A run with a period of one and a pass with input changes but no strobe cover the degenerate period and the shadowing.

// File: rtl/mphase_pwm_pkg.sv
package mphase_pwm_pkg;

  localparam int unsigned MAX_UNITS = 6;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_RUN  = 1'b1
  } mstate_e;

endpackage

// File: rtl/mphase_pwm_master.sv
module mphase_pwm_master
  import mphase_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             boundary_o,
  output logic             start_o
);

  localparam logic [CNT_W:0]   ONE_X = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  mstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc_x;
  logic             last_tick;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    cnt_inc_x = {1'b0, cnt_q} + ONE_X;
    last_tick = (cnt_inc_x >= {1'b0, period_i});
    state_d   = enable_i ? MS_RUN : MS_IDLE;
    cnt_en    = enable_i || (state_q == MS_RUN);
    if (!enable_i || (state_q == MS_IDLE) || last_tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc_x[CNT_W-1:0];
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign run_o      = (state_q == MS_RUN);
  assign boundary_o = (state_q == MS_IDLE) || last_tick;
  assign start_o    = (state_q == MS_RUN) && (cnt_q == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == MS_RUN) && (period_i > ONE)) |-> (cnt_q < period_i))
    else $error("master count outside period"); // R3

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && (period_i > ONE)) |=> !start_o)
    else $error("period start longer than one cycle"); // R3

endmodule

// File: rtl/mphase_pwm_regs.sv
module mphase_pwm_regs #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       update_i,
  input  logic                       boundary_i,
  input  logic [CNT_W-1:0]           period_i,
  input  logic [NUM_UNITS*CNT_W-1:0] duty_i,
  input  logic [NUM_UNITS*CNT_W-1:0] offset_i,
  output logic [CNT_W-1:0]           act_period_o,
  output logic [NUM_UNITS*CNT_W-1:0] act_duty_o,
  output logic [NUM_UNITS*CNT_W-1:0] act_off_o
);

  localparam int unsigned BUS_W = NUM_UNITS * CNT_W;

  logic [CNT_W-1:0] sh_period_q;
  logic [BUS_W-1:0] sh_duty_q;
  logic [BUS_W-1:0] sh_off_q;
  logic [BUS_W-1:0] eff_off;
  logic             pend_q, pend_d;
  logic             load;

  // offsets that do not fit inside the period collapse to zero
  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_eff
    assign eff_off[k*CNT_W +: CNT_W] =
      (sh_off_q[k*CNT_W +: CNT_W] >= sh_period_q) ? '0 : sh_off_q[k*CNT_W +: CNT_W];
  end

  always_comb begin
    load   = pend_q && boundary_i;
    pend_d = update_i || (pend_q && !load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period_q <= '0;
      sh_duty_q   <= '0;
      sh_off_q    <= '0;
      pend_q      <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (update_i) begin
        sh_period_q <= period_i;
        sh_duty_q   <= duty_i;
        sh_off_q    <= offset_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_period_o <= '0;
      act_duty_o   <= '0;
      act_off_o    <= '0;
    end else if (load) begin
      act_period_o <= sh_period_q;
      act_duty_o   <= sh_duty_q;
      act_off_o    <= eff_off;
    end
  end

  AST_PEND_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> pend_q)
    else $error("strobe not recorded"); // R7

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_duty_o) && $stable(act_period_o) && $stable(act_off_o)))
    else $error("active set changed without a load"); // R8

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_off_chk
    AST_OFF_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_off_o[k*CNT_W +: CNT_W] != '0) |-> (act_off_o[k*CNT_W +: CNT_W] < act_period_o))
      else $error("active offset not below period"); // R6
  end

endmodule

// File: rtl/mphase_pwm_unit.sv
module mphase_pwm_unit #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] mcnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic             pwm_o
);

  logic [CNT_W-1:0] phase_cnt;

  // (master - offset) mod period; offset is already below period or zero
  always_comb begin
    if (mcnt_i >= offset_i) begin
      phase_cnt = mcnt_i - offset_i;
    end else begin
      phase_cnt = mcnt_i + (period_i - offset_i);
    end
    pwm_o = run_i && (phase_cnt < duty_i);
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (period_i != '0)) |-> (phase_cnt < period_i))
    else $error("phase counter outside period"); // R4

  AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> !pwm_o)
    else $error("zero duty produced a high output"); // R5

  AST_DUTY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (duty_i != '0) && (duty_i >= period_i)) |-> pwm_o)
    else $error("full duty produced a low output"); // R5

endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
  import mphase_pwm_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable_i,
  input  logic                       update_i,
  input  logic [CNT_W-1:0]           period_i,
  input  logic [NUM_UNITS*CNT_W-1:0] duty_i,
  input  logic [NUM_UNITS*CNT_W-1:0] offset_i,
  output logic [NUM_UNITS-1:0]       pwm_o,
  output logic                       period_start_o
);

  localparam int unsigned BUS_W = NUM_UNITS * CNT_W;

  if ((NUM_UNITS < 1) || (NUM_UNITS > MAX_UNITS)) begin : g_bad_cfg
    $error("NUM_UNITS must lie between 1 and MAX_UNITS");
  end

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [CNT_W-1:0] mcnt;
  logic             run;
  logic             boundary;
  logic [CNT_W-1:0] act_period;
  logic [BUS_W-1:0] act_duty;
  logic [BUS_W-1:0] act_off;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  mphase_pwm_master #(
    .CNT_W (CNT_W)
  ) u_master (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .enable_i   (enable_i),
    .period_i   (act_period),
    .cnt_o      (mcnt),
    .run_o      (run),
    .boundary_o (boundary),
    .start_o    (period_start_o)
  );

  mphase_pwm_regs #(
    .NUM_UNITS (NUM_UNITS),
    .CNT_W     (CNT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .update_i     (update_i),
    .boundary_i   (boundary),
    .period_i     (period_i),
    .duty_i       (duty_i),
    .offset_i     (offset_i),
    .act_period_o (act_period),
    .act_duty_o   (act_duty),
    .act_off_o    (act_off)
  );

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    mphase_pwm_unit #(
      .CNT_W (CNT_W)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .run_i    (run),
      .mcnt_i   (mcnt),
      .period_i (act_period),
      .duty_i   (act_duty[k*CNT_W +: CNT_W]),
      .offset_i (act_off[k*CNT_W +: CNT_W]),
      .pwm_o    (pwm_o[k])
    );
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !enable_i |=> ((pwm_o == '0) && !period_start_o))
    else $error("outputs active while disabled"); // R2

  AST_CFG_AT_START: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!$stable(act_duty) || !$stable(act_period) || !$stable(act_off)) |-> (mcnt == '0))
    else $error("active set switched mid-period"); // R7

endmodule

// File: tb/mphase_pwm_bench.sv
module mphase_pwm_bench;

  localparam int NU = 4;
  localparam int CW = 16;

  logic              clk;
  logic              rst_n;
  logic              enable_i;
  logic              update_i;
  logic [CW-1:0]     period_i;
  logic [NU*CW-1:0]  duty_i;
  logic [NU*CW-1:0]  offset_i;
  logic [NU-1:0]     pwm_o;
  logic              period_start_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // expected active configuration and observed master count
  int e_p;
  int e_duty [NU];
  int e_off  [NU];
  int drv_p;
  int drv_duty [NU];
  int drv_off  [NU];
  int m_obs;

  mphase_pwm #(
    .NUM_UNITS (NU),
    .CNT_W     (CW)
  ) u_mphase_pwm (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable_i       (enable_i),
    .update_i       (update_i),
    .period_i       (period_i),
    .duty_i         (duty_i),
    .offset_i       (offset_i),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finished)");
      summary();
      $finish;
    end
  end

  task automatic check_eq(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at t=%0t: actual %0h expected %0h", req, $time, got, exp);
    end
  endtask

  // R4, R5, R6 expected level of unit k at master count m
  function automatic logic exp_bit(int k, int m);
    int off;
    int ph;
    off = (e_off[k] >= e_p) ? 0 : e_off[k];
    if (e_p <= 1) ph = 0;
    else ph = (m - off + e_p) % e_p;
    return ph < e_duty[k];
  endfunction

  task automatic check_cycle(string req);
    logic [NU-1:0] exp_v;
    for (int k = 0; k < NU; k++) exp_v[k] = exp_bit(k, m_obs);
    check_eq({req, " pwm"}, int'(pwm_o), int'(exp_v));
    check_eq({req, " R3 start"}, int'(period_start_o), (m_obs == 0) ? 1 : 0);
  endtask

  task automatic advance();
    @(negedge clk);
    if (e_p <= 1) m_obs = 0;
    else m_obs = (m_obs + 1) % e_p;
  endtask

  task automatic window(int n, string req);
    for (int i = 0; i < n; i++) begin
      check_cycle(req);
      advance();
    end
  endtask

  // R9 packing: unit k in bits [k*CW +: CW]
  task automatic drive_cfg(int p, int d0, int d1, int d2, int d3,
                           int o0, int o1, int o2, int o3);
    drv_p = p;
    drv_duty[0] = d0; drv_duty[1] = d1; drv_duty[2] = d2; drv_duty[3] = d3;
    drv_off[0]  = o0; drv_off[1]  = o1; drv_off[2]  = o2; drv_off[3]  = o3;
    period_i = CW'(p);
    for (int k = 0; k < NU; k++) begin
      duty_i[k*CW +: CW]   = CW'(drv_duty[k]);
      offset_i[k*CW +: CW] = CW'(drv_off[k]);
    end
  endtask

  task automatic adopt();
    e_p = drv_p;
    for (int k = 0; k < NU; k++) begin
      e_duty[k] = drv_duty[k];
      e_off[k]  = drv_off[k];
    end
  endtask

  task automatic check_quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      check_eq({req, " pwm low"}, int'(pwm_o), 0);
      check_eq({req, " start low"}, int'(period_start_o), 0);
      @(negedge clk);
    end
  endtask

  // idle load then start: strobe, enable, first cycle has m = 0
  task automatic start_with_strobe();
    update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
    enable_i = 1'b1;
    adopt();
    @(negedge clk);
    m_obs = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable_i = 1'b0; update_i = 1'b0;
    drive_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check_quiet(2, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet(2, "R1 after reset");
  endtask

  task automatic t_interleave();
    drive_cfg(12, 6, 6, 6, 6, 0, 3, 6, 9);
    start_with_strobe();
    window(36, "R4 R9 quarter interleave");
  endtask

  task automatic t_extremes();
    enable_i = 1'b0;
    @(negedge clk);
    check_quiet(2, "R2 disable");
    drive_cfg(12, 0, 12, 20, 5, 4, 2, 0, 15);
    start_with_strobe();
    window(24, "R5 R6 extremes");
  endtask

  task automatic t_sync_update();
    window(5, "R7 before strobe");
    check_cycle("R7 strobe cycle");
    drive_cfg(8, 2, 3, 4, 7, 0, 2, 4, 6);
    update_i = 1'b1;
    advance();
    update_i = 1'b0;
    window(6, "R7 old set holds");
    adopt();
    window(16, "R7 new set at rollover");
  endtask

  task automatic t_boundary_strobe();
    window(7, "R7 pre last");
    check_cycle("R7 last cycle strobe");
    drive_cfg(10, 1, 9, 5, 3, 9, 1, 5, 7);
    update_i = 1'b1;
    advance();
    update_i = 1'b0;
    window(8, "R7 deferred one period");
    adopt();
    window(20, "R7 deferred set active");
  endtask

  task automatic t_no_strobe();
    drive_cfg(12, 6, 6, 6, 6, 0, 3, 6, 9);
    window(30, "R8 inputs without strobe");
  endtask

  task automatic t_reenable();
    enable_i = 1'b0;
    @(negedge clk);
    check_quiet(5, "R2 held disabled");
    enable_i = 1'b1;
    @(negedge clk);
    m_obs = 0;
    window(10, "R2 restart at zero");
  endtask

  task automatic t_period_one();
    enable_i = 1'b0;
    @(negedge clk);
    drive_cfg(1, 0, 1, 1, 0, 0, 0, 3, 0);
    start_with_strobe();
    window(6, "R3 period one");
  endtask

  initial begin
    m_obs = 0;
    e_p = 0;
    for (int k = 0; k < NU; k++) begin
      e_duty[k] = 0;
      e_off[k]  = 0;
    end
    @(negedge clk);
    t_reset();
    t_interleave();
    t_extremes();
    t_sync_update();
    t_boundary_strobe();
    t_no_strobe();
    t_reenable();
    t_period_one();
    done = 1;
    summary();
    $finish;
  end

endmodule